// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Mode

This block carries words from a producer clocked by `wclk` to a consumer clocked by `rclk`. The two clocks may be unrelated or the very same clock. Each pointer crosses to the other domain in Gray code through a two-flop synchronizer. Because of this, a flag that depends on the far side clears late: two to three cycles of the local clock after the event. The flag never clears early. Each port transfers a word only when its select is low and its enable is high.

One mode input picks between two read behaviours. In standard mode a granted read loads `r_data` on that clock edge. The read-side flag then means "memory empty" and the write-side flag means "memory full". In fall-through mode the oldest stored word is moved to `r_data` without any request. The read-side flag then means "a valid word is on `r_data`" and the write-side flag means "there is room to write". Both ports behave as valid/ready streams. On the write side `w_en` is the valid, and the ready is `!w_flag` in standard mode or `w_flag` in fall-through mode. A word offered while not ready is dropped, so the producer must hold it and offer it again. On the read side in fall-through mode `r_flag` is the valid and `r_en` is the ready; the word stays on `r_data` until it is taken. Two active-low level flags report when the FIFO is nearly empty or nearly full, using thresholds captured at reset.

Top module: `dcfifo_flagmode`

## Requirements
- R1: A port moves a word only on a rising edge of its own clock at which its select is low and its enable is high. With `w_cs_n` high, the write pointer does not move.
- R2: `r_oe` is high exactly while `r_cs_n` is low. It marks the cycles in which `r_data` would be driven onto a shared bus.
- R3: In standard mode `r_flag` is 1 while the memory is empty. A granted read loads the oldest word into `r_data` on that edge. A read attempted while empty leaves `r_data` and the read pointer unchanged.
- R4: In standard mode `w_flag` is 1 while the memory holds 2^AW words. A write attempted while full is discarded and never reaches the reader.
- R5: In fall-through mode the oldest word moves to `r_data` with no read request, and `r_flag` rises with it. `r_flag` and `r_data` hold until that word is taken with `r_cs_n` low and `r_en` high.
- R6: In fall-through mode `w_flag` is 1 while the memory can accept a write, and 0 when it is full.
- R7: `r_aempty_n` is 0 when the stored word count is at or below the captured `ae_offset`, and 1 otherwise. In fall-through mode the count includes the word held on `r_data`. The flag is driven from `rclk` registers.
- R8: `w_afull_n` is 0 when the number of free memory locations is at or below the captured `af_offset`, and 1 otherwise. The flag is driven from `wclk` registers.
- R9: The first edge of each clock after its reset is released captures `mode_std` (1 selects standard mode, 0 selects fall-through mode) and that side's offset. Both then stay fixed until the next reset.
- R10: Words leave in the order they were accepted, with none lost or repeated, while both ports run at the same time on unrelated clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| w_cs_n | input | 1 | Write select, active low |
| w_en | input | 1 | Write enable (stream valid) |
| w_data | input | DW | Word to store |
| w_flag | output | 1 | Full (standard mode) or room available (fall-through mode) |
| w_afull_n | output | 1 | Almost-full, active low |
| af_offset | input | AW+1 | Almost-full threshold, captured after reset |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| r_cs_n | input | 1 | Read select, active low |
| r_en | input | 1 | Read enable (stream ready) |
| r_data | output | DW | Output word register |
| r_oe | output | 1 | Output drive enable |
| r_flag | output | 1 | Empty (standard mode) or word valid (fall-through mode) |
| r_aempty_n | output | 1 | Almost-empty, active low |
| ae_offset | input | AW+1 | Almost-empty threshold, captured after reset |
| mode_std | input | 1 | 1 selects standard mode, 0 selects fall-through mode |

## Verification
The bench drives both thresholds at exactly their boundary counts, one word above and at the offset. A design with an off-by-one compare would switch a level flag one word early or late. It fills the memory and keeps offering a marked word while full, then empties it and reads again while empty. A FIFO that wrapped its pointer would hand the marked word back, and one that read while empty would change `r_data`. In fall-through mode it writes a single word and never asks for it. A design without the output stage would leave `r_flag` low, or would show a word that then disappears before it is taken. Finally, concurrent streams on 10 ns and 13 ns clocks check the ordering across the Gray-code crossing.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    MODE_FWFT = 1'b0,
    MODE_STD  = 1'b1
  } mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_g2b.sv
module dcf_g2b #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  assign bin[W-1] = gray[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_bit
    assign bin[i] = bin[i+1] ^ gray[i];
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          en,
  input  logic          mode_in,
  input  logic [PW-1:0] af_off_in,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          wfire,
  output logic          flag,
  output logic          afull_n,
  output logic [PW-1:0] level,
  output logic          is_std
);
  localparam logic [PW-1:0] FULL_LVL = {1'b1, {AW{1'b0}}};

  logic          cfg_done;
  mode_e         mode_q;
  logic [PW-1:0] af_q;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] free_cnt;
  logic [PW-1:0] wbin_n;
  logic          full;

  dcf_g2b #(.W(PW)) u_g2b (.gray(rgray_s), .bin(rbin_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      mode_q   <= MODE_STD;
      af_q     <= '0;
    end else if (!cfg_done) begin
      cfg_done <= 1'b1;
      mode_q   <= mode_e'(mode_in);
      af_q     <= af_off_in;
    end
  end

  assign level    = wbin - rbin_s;
  assign full     = (level == FULL_LVL);
  assign free_cnt = FULL_LVL - level;
  assign wfire    = cfg_done && !cs_n && en && !full;
  assign wbin_n   = wbin + {{AW{1'b0}}, wfire};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
    end
  end

  assign is_std  = (mode_q == MODE_STD);
  assign flag    = is_std ? full : !full;
  assign afull_n = !(free_cnt <= af_q);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          en,
  input  logic          mode_in,
  input  logic [PW-1:0] ae_off_in,
  input  logic [PW-1:0] wgray_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] rdata,
  output logic          flag,
  output logic          aempty_n,
  output logic [PW-1:0] level,
  output logic          is_std
);
  logic          cfg_done;
  mode_e         mode_q;
  logic [PW-1:0] ae_q;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] mem_level;
  logic [PW-1:0] rbin_n;
  logic          mem_empty;
  logic          out_vld;
  logic          std_fire;
  logic          pop;
  logic          load;
  logic          adv;

  dcf_g2b #(.W(PW)) u_g2b (.gray(wgray_s), .bin(wbin_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      mode_q   <= MODE_STD;
      ae_q     <= '0;
    end else if (!cfg_done) begin
      cfg_done <= 1'b1;
      mode_q   <= mode_e'(mode_in);
      ae_q     <= ae_off_in;
    end
  end

  assign is_std    = (mode_q == MODE_STD);
  assign mem_level = wbin_s - rbin;
  assign mem_empty = (mem_level == '0);
  assign std_fire  = cfg_done && is_std && !cs_n && en && !mem_empty;
  assign pop       = !is_std && out_vld && !cs_n && en;
  assign load      = cfg_done && !is_std && !mem_empty && (!out_vld || pop);
  assign adv       = std_fire || load;
  assign rbin_n    = rbin + {{AW{1'b0}}, adv};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rdata   <= '0;
      out_vld <= 1'b0;
    end else begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
      if (adv) rdata <= mem_rdata;
      if (load)     out_vld <= 1'b1;
      else if (pop) out_vld <= 1'b0;
    end
  end

  assign level    = mem_level + {{AW{1'b0}}, (!is_std && out_vld)};
  assign flag     = is_std ? mem_empty : out_vld;
  assign aempty_n = !(level <= ae_q);
endmodule

// File: rtl/dcfifo_flagmode.sv
module dcfifo_flagmode
  import dcf_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 36,
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          w_cs_n,
  input  logic          w_en,
  input  logic [DW-1:0] w_data,
  output logic          w_flag,
  output logic          w_afull_n,
  input  logic [PW-1:0] af_offset,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          r_cs_n,
  input  logic          r_en,
  output logic [DW-1:0] r_data,
  output logic          r_oe,
  output logic          r_flag,
  output logic          r_aempty_n,
  input  logic [PW-1:0] ae_offset,
  input  logic          mode_std
);
  logic [PW-1:0] w_ptr, w_gray, r_ptr, r_gray;
  logic [PW-1:0] r_gray_w, w_gray_r;
  logic [PW-1:0] w_level, r_level;
  logic [DW-1:0] mem_q;
  logic          w_fire, w_std, r_std;

  dcf_wr_side #(.AW(AW)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .cs_n(w_cs_n), .en(w_en),
    .mode_in(mode_std), .af_off_in(af_offset), .rgray_s(r_gray_w),
    .wbin(w_ptr), .wgray(w_gray), .wfire(w_fire), .flag(w_flag),
    .afull_n(w_afull_n), .level(w_level), .is_std(w_std)
  );

  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(r_gray), .q(r_gray_w));
  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(w_gray), .q(w_gray_r));

  dcf_mem #(.AW(AW), .DW(DW)) u_mem (
    .wclk(wclk), .we(w_fire), .waddr(w_ptr[AW-1:0]), .wdata(w_data),
    .raddr(r_ptr[AW-1:0]), .rdata(mem_q)
  );

  dcf_rd_side #(.AW(AW), .DW(DW)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .cs_n(r_cs_n), .en(r_en),
    .mode_in(mode_std), .ae_off_in(ae_offset), .wgray_s(w_gray_r),
    .mem_rdata(mem_q), .rbin(r_ptr), .rgray(r_gray), .rdata(r_data),
    .flag(r_flag), .aempty_n(r_aempty_n), .level(r_level), .is_std(r_std)
  );

  assign r_oe = !r_cs_n;
endmodule

// File: rtl/dcfifo_flagmode_chk.sv
module dcfifo_flagmode_chk #(
  parameter int AW = 6,
  parameter int DW = 36,
  localparam int PW = AW + 1
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          w_cs_n,
  input logic          w_en,
  input logic          r_cs_n,
  input logic          r_en,
  input logic          w_flag,
  input logic          r_flag,
  input logic [DW-1:0] r_data,
  input logic [PW-1:0] w_level,
  input logic [PW-1:0] w_ptr,
  input logic [PW-1:0] r_ptr,
  input logic          w_std,
  input logic          r_std
);
  localparam logic [PW-1:0] FULL_LVL = {1'b1, {AW{1'b0}}};

  // R4
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_level <= FULL_LVL);

  // R4
  full_write_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (w_std && w_flag && !w_cs_n && w_en) |=> (w_ptr == $past(w_ptr)));

  // R1
  cs_block_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_cs_n |=> (w_ptr == $past(w_ptr)));

  // R3
  empty_read_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (r_std && r_flag && !r_cs_n && r_en) |=> ($stable(r_data) && $stable(r_ptr)));

  // R5
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!r_std && r_flag && !(!r_cs_n && r_en)) |=> (r_flag && $stable(r_data)));
endmodule

bind dcfifo_flagmode dcfifo_flagmode_chk #(.AW(AW), .DW(DW)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .w_cs_n(w_cs_n), .w_en(w_en), .r_cs_n(r_cs_n), .r_en(r_en),
  .w_flag(w_flag), .r_flag(r_flag), .r_data(r_data), .w_level(w_level),
  .w_ptr(w_ptr), .r_ptr(r_ptr), .w_std(w_std), .r_std(r_std)
);

// File: tb/dcfifo_flagmode_tb.sv
module dcfifo_flagmode_tb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic w_cs_n = 1'b1, w_en = 1'b0, r_cs_n = 1'b1, r_en = 1'b0;
  logic [DW-1:0] w_data = '0;
  logic mode_std = 1'b1;
  logic [PW-1:0] ae_offset = PW'(2), af_offset = PW'(3);
  logic [DW-1:0] r_data;
  logic w_flag, w_afull_n, r_oe, r_flag, r_aempty_n;

  int tests = 0, fails = 0, sched = 0;
  logic pend = 1'b0;
  logic [DW-1:0] last_rd = '0;
  logic [DW-1:0] sb[$];

  always #5 wclk = ~wclk;
  always #6.5 rclk = ~rclk;

  dcfifo_flagmode #(.AW(AW), .DW(DW)) u_dut (
    .wclk(wclk), .wrst_n(wrst_n), .w_cs_n(w_cs_n), .w_en(w_en), .w_data(w_data),
    .w_flag(w_flag), .w_afull_n(w_afull_n), .af_offset(af_offset),
    .rclk(rclk), .rrst_n(rrst_n), .r_cs_n(r_cs_n), .r_en(r_en), .r_data(r_data),
    .r_oe(r_oe), .r_flag(r_flag), .r_aempty_n(r_aempty_n), .ae_offset(ae_offset),
    .mode_std(mode_std)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_word(input logic [DW-1:0] got);
    logic [DW-1:0] exp;
    if (sb.size() == 0) begin
      check(1'b0, "R10 read with empty scoreboard", int'(got), 0);
    end else begin
      exp = sb.pop_front();
      check(got == exp, "R10 order", int'(got), int'(exp));
    end
    last_rd = got;
  endtask

  // monitor: pops the scoreboard as the design delivers words
  always @(negedge rclk) begin
    if (pend) begin
      pend = 1'b0;
      compare_word(r_data);
    end
    if (rrst_n && !r_cs_n && r_en) begin
      if (mode_std && !r_flag) begin
        pend = 1'b1;
        sched++;
      end else if (!mode_std && r_flag) begin
        compare_word(r_data);
        sched++;
      end
    end
  end

  // driver: offers words until n are accepted
  task automatic write_words(input int n, input logic [DW-1:0] base);
    int got = 0;
    @(posedge wclk); #1;
    w_cs_n = 1'b0; w_en = 1'b1; w_data = base;
    while (got < n) begin
      @(negedge wclk);
      if (mode_std ? !w_flag : w_flag) begin
        sb.push_back(w_data);
        got++;
      end
      @(posedge wclk); #1;
      w_data = base + DW'(got);
    end
    w_en = 1'b0; w_cs_n = 1'b1;
  endtask

  task automatic read_words(input int n);
    int tgt = sched + n;
    @(posedge rclk); #1;
    r_cs_n = 1'b0; r_en = 1'b1;
    while (sched < tgt) begin
      @(posedge rclk); #1;
    end
    r_en = 1'b0; r_cs_n = 1'b1;
  endtask

  task automatic do_reset(input logic m);
    mode_std = m;
    wrst_n = 1'b0; rrst_n = 1'b0;
    repeat (4) @(posedge rclk);
    #1 wrst_n = 1'b1; rrst_n = 1'b1;
    repeat (6) @(posedge rclk);
    @(negedge wclk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    // ---------------- standard mode ----------------
    do_reset(1'b1);
    check(r_flag == 1'b1, "R9 R3 empty after reset", r_flag, 1);
    check(w_flag == 1'b0, "R9 R4 not full after reset", w_flag, 0);
    check(r_aempty_n == 1'b0, "R7 aempty at 0 words", r_aempty_n, 0);
    check(w_afull_n == 1'b1, "R8 afull idle", w_afull_n, 1);
    check(r_oe == 1'b0, "R2 oe off", r_oe, 0);
    @(posedge rclk); #1 r_cs_n = 1'b0;
    @(negedge rclk);
    check(r_oe == 1'b1, "R2 oe on", r_oe, 1);
    @(posedge rclk); #1 r_cs_n = 1'b1;

    // R1: enable with select high moves nothing
    @(posedge wclk); #1 w_cs_n = 1'b1; w_en = 1'b1; w_data = 16'hBAD0;
    repeat (5) @(posedge wclk);
    #1 w_en = 1'b0;
    repeat (8) @(negedge rclk);
    check(r_flag == 1'b1, "R1 deselected write stored", r_flag, 1);

    // R8 boundary
    write_words(DEPTH - 4, 16'h1000);
    @(negedge wclk);
    check(w_afull_n == 1'b1, "R8 free=4 above offset", w_afull_n, 1);
    write_words(1, 16'h1100);
    @(negedge wclk);
    check(w_afull_n == 1'b0, "R8 free=3 at offset", w_afull_n, 0);
    write_words(3, 16'h1200);
    @(negedge wclk);
    check(w_flag == 1'b1, "R4 full at depth", w_flag, 1);
    // R4: marked word offered while full, not pushed to scoreboard
    @(posedge wclk); #1 w_cs_n = 1'b0; w_en = 1'b1; w_data = 16'hDEAD;
    repeat (3) @(posedge wclk);
    #1 w_en = 1'b0; w_cs_n = 1'b1;
    @(negedge wclk);
    check(w_flag == 1'b1, "R4 still full", w_flag, 1);

    repeat (6) @(negedge rclk);
    check(r_aempty_n == 1'b1, "R7 full store", r_aempty_n, 1);
    check(r_flag == 1'b0, "R3 not empty", r_flag, 0);
    read_words(DEPTH - 3);
    @(negedge rclk);
    check(r_aempty_n == 1'b1, "R7 3 words above offset", r_aempty_n, 1);
    read_words(1);
    @(negedge rclk);
    check(r_aempty_n == 1'b0, "R7 2 words at offset", r_aempty_n, 0);
    read_words(2);
    repeat (2) @(negedge rclk);
    check(r_flag == 1'b1, "R3 R4 empty after depth reads", r_flag, 1);
    check(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);

    // R3: read while empty leaves output alone
    held = r_data;
    @(posedge rclk); #1 r_cs_n = 1'b0; r_en = 1'b1;
    repeat (4) @(posedge rclk);
    #1 r_en = 1'b0; r_cs_n = 1'b1;
    @(negedge rclk);
    check(r_data == held, "R3 read while empty", int'(r_data), int'(held));
    check(r_data == 16'h1202, "R3 last word kept, no DEAD", int'(r_data), 16'h1202);
    repeat (6) @(negedge wclk);
    check(w_flag == 1'b0, "R4 full clears after drain", w_flag, 0);

    // R10 concurrent stream
    fork
      write_words(40, 16'h2000);
      read_words(40);
    join
    repeat (4) @(negedge rclk);
    check(sb.size() == 0, "R10 std stream complete", sb.size(), 0);

    // ---------------- fall-through mode ----------------
    do_reset(1'b0);
    check(w_flag == 1'b1, "R9 R6 ready after reset", w_flag, 1);
    check(r_flag == 1'b0, "R9 R5 no valid after reset", r_flag, 0);
    write_words(1, 16'h3456);
    repeat (8) @(negedge rclk);
    check(r_flag == 1'b1, "R5 fall-through valid", r_flag, 1);
    check(r_data == 16'h3456, "R5 fall-through data", int'(r_data), 16'h3456);
    check(r_aempty_n == 1'b0, "R7 one word on output counted", r_aempty_n, 0);
    read_words(1);
    @(negedge rclk);
    check(r_flag == 1'b0, "R5 valid drops after take", r_flag, 0);

    write_words(DEPTH + 1, 16'h4000);
    @(negedge wclk);
    check(w_flag == 1'b0, "R6 not ready when full", w_flag, 0);
    repeat (6) @(negedge rclk);
    check(r_aempty_n == 1'b1, "R7 fwft full count", r_aempty_n, 1);
    read_words(DEPTH + 1);
    repeat (2) @(negedge rclk);
    check(r_flag == 1'b0, "R5 drained", r_flag, 0);
    repeat (6) @(negedge wclk);
    check(w_flag == 1'b1, "R6 ready after drain", w_flag, 1);

    fork
      write_words(40, 16'h5000);
      read_words(40);
    join
    repeat (4) @(negedge rclk);
    check(sb.size() == 0, "R10 fwft stream complete", sb.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule